// File: doc/BRIEF.md
# RTC Boundary Event Detector

This block watches the running counters of a real-time clock (seconds, minutes, hours, day of week, day of month and month). It raises two sticky flags when a chosen boundary is crossed. One flag is a time-of-day event and the other is a calendar event. A 2-bit selector picks the boundary for each flag. A UTC-mode input turns both event sources off.

The counters are sampled only on a one-cycle second strobe. That strobe comes from the counter logic in the same cycle as the freshly updated values. A boundary fires on the strobe where the new counter values first meet the boundary condition. Repeated strobes with the same matching values do not fire again. Each flag is registered and stays set until its own clear strobe arrives. Software or a neighbouring status block reads the flags and clears them.

Top module: `rtc_evt_detect`

## Requirements
- R1: After a synchronous reset, both `time_evt_flag` and `cal_evt_flag` read 0.
- R2: With `time_sel` = 0 (minute), a strobe whose seconds value is 0 sets `time_evt_flag` on the next clock edge. A strobe with any other seconds value does not set it.
- R3: With `time_sel` = 1 (hour), the time flag is set on a strobe whose minutes and seconds are both 0.
- R4: With `time_sel` = 2 (midnight), the time flag is set on a strobe at 00:00:00. With `time_sel` = 3 (noon), it is set on a strobe at 12:00:00. Hours are binary 0 to 23.
- R5: With `cal_sel` = 0 (week), the calendar flag is set on a strobe at 00:00:00 when the day of week is 1 (Monday). Days of week are coded 1 to 7.
- R6: With `cal_sel` = 1 (month), the calendar flag is set on a strobe at 00:00:00 when the date is 1. With `cal_sel` = 2 (year), it is set at 00:00:00 when the date is 1 and the month is 1 (January). Months are coded 1 to 12.
- R7: `cal_sel` = 3 is reserved and never sets the calendar flag.
- R8: While `utc_mode` is 1, neither flag is set by any strobe.
- R9: An event fires only on a strobe, and only once per crossing. A later strobe that presents the same matching value again does not fire, and matching values without a strobe do not fire. The edge history is cleared by reset.
- R10: Each flag stays set until its own clear strobe. A clear alone drops the flag on the next edge. A new event and a clear in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle strobe marking freshly updated counters |
| sec_cnt | input | SEC_W | Seconds, binary 0..59 |
| min_cnt | input | MIN_W | Minutes, binary 0..59 |
| hour_cnt | input | HOUR_W | Hours, binary 0..23 |
| wday_cnt | input | WDAY_W | Day of week, 1 = Monday .. 7 |
| date_cnt | input | DATE_W | Day of month, 1..31 |
| month_cnt | input | MONTH_W | Month, 1 = January .. 12 |
| time_sel | input | 2 | Time boundary: 0 minute, 1 hour, 2 midnight, 3 noon |
| cal_sel | input | 2 | Calendar boundary: 0 week, 1 month, 2 year, 3 reserved |
| utc_mode | input | 1 | Disables both event sources when 1 |
| time_clr | input | 1 | Clear strobe for the time flag |
| cal_clr | input | 1 | Clear strobe for the calendar flag |
| time_evt_flag | output | 1 | Sticky time event flag |
| cal_evt_flag | output | 1 | Sticky calendar event flag |

## Verification
The bench builds the block with its default widths: 6-bit seconds and minutes, 5-bit hours and dates, a 3-bit weekday and a 4-bit month. With these widths, every boundary value and its near misses can be driven directly, for example 12:00:00 against 12:00:01 and date 1 in month 2 against month 1. Noon stays at hour 12 and Monday at code 1, so the bench can check hour 12 under the midnight selector as well as under the noon selector.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;
  // Index of each boundary in the match vector
  localparam int BND_MINUTE   = 0;
  localparam int BND_HOUR     = 1;
  localparam int BND_MIDNIGHT = 2;
  localparam int BND_NOON     = 3;
  localparam int BND_WEEK     = 4;
  localparam int BND_MONTH    = 5;
  localparam int BND_YEAR     = 6;
  localparam int BND_COUNT    = 7;
  localparam int TIME_BASE    = BND_MINUTE;
  localparam int CAL_BASE     = BND_WEEK;

  typedef enum logic [1:0] {
    TSEL_MINUTE   = 2'd0,
    TSEL_HOUR     = 2'd1,
    TSEL_MIDNIGHT = 2'd2,
    TSEL_NOON     = 2'd3
  } time_sel_e;

  typedef enum logic [1:0] {
    CSEL_WEEK  = 2'd0,
    CSEL_MONTH = 2'd1,
    CSEL_YEAR  = 2'd2,
    CSEL_NONE  = 2'd3
  } cal_sel_e;
endpackage

// File: rtl/rtc_evt_match.sv
module rtc_evt_match
  import rtc_evt_pkg::*;
#(
  parameter int SEC_W      = 6,
  parameter int MIN_W      = 6,
  parameter int HOUR_W     = 5,
  parameter int WDAY_W     = 3,
  parameter int DATE_W     = 5,
  parameter int MONTH_W    = 4,
  parameter int NOON_HOUR  = 12,
  parameter int MONDAY_VAL = 1,
  parameter int FIRST_DATE = 1,
  parameter int JAN_VAL    = 1
) (
  input  logic [SEC_W-1:0]     sec_cnt,
  input  logic [MIN_W-1:0]     min_cnt,
  input  logic [HOUR_W-1:0]    hour_cnt,
  input  logic [WDAY_W-1:0]    wday_cnt,
  input  logic [DATE_W-1:0]    date_cnt,
  input  logic [MONTH_W-1:0]   month_cnt,
  output logic [BND_COUNT-1:0] match
);
  localparam logic [HOUR_W-1:0]  NOON_H = HOUR_W'(NOON_HOUR);
  localparam logic [WDAY_W-1:0]  MON_D  = WDAY_W'(MONDAY_VAL);
  localparam logic [DATE_W-1:0]  DATE1  = DATE_W'(FIRST_DATE);
  localparam logic [MONTH_W-1:0] JAN_M  = MONTH_W'(JAN_VAL);

  logic top_of_minute, top_of_hour, at_midnight;

  always_comb begin
    top_of_minute = (sec_cnt == '0);
    top_of_hour   = top_of_minute && (min_cnt == '0);
    at_midnight   = top_of_hour && (hour_cnt == '0);
    match                = '0;
    match[BND_MINUTE]    = top_of_minute;
    match[BND_HOUR]      = top_of_hour;
    match[BND_MIDNIGHT]  = at_midnight;
    match[BND_NOON]      = top_of_hour && (hour_cnt == NOON_H);
    match[BND_WEEK]      = at_midnight && (wday_cnt == MON_D);
    match[BND_MONTH]     = at_midnight && (date_cnt == DATE1);
    match[BND_YEAR]      = at_midnight && (date_cnt == DATE1) && (month_cnt == JAN_M);
  end
endmodule

// File: rtl/rtc_evt_edge.sv
module rtc_evt_edge #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [N-1:0] match,
  output logic [N-1:0] fire
);
  // One history bit per boundary so a selector change cannot re-fire a held value
  for (genvar i = 0; i < N; i++) begin : g_bnd
    logic seen_q;

    always_ff @(posedge clk) begin
      if (rst)       seen_q <= 1'b0;
      else if (tick) seen_q <= match[i];
    end

    assign fire[i] = tick && match[i] && !seen_q;

    AST_FIRE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
      fire[i] |-> tick);                                        // R9
    AST_FIRE_ONCE: assert property (@(posedge clk) disable iff (rst)
      fire[i] |=> !fire[i]);                                    // R9
  end
endmodule

// File: rtl/rtc_evt_flag.sv
module rtc_evt_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set |=> flag);                                              // R10
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !flag);                                   // R10
  AST_RISE_FROM_SET: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(set));                                // R10
endmodule

// File: rtl/rtc_evt_detect.sv
module rtc_evt_detect
  import rtc_evt_pkg::*;
#(
  parameter int SEC_W      = 6,
  parameter int MIN_W      = 6,
  parameter int HOUR_W     = 5,
  parameter int WDAY_W     = 3,
  parameter int DATE_W     = 5,
  parameter int MONTH_W    = 4,
  parameter int NOON_HOUR  = 12,
  parameter int MONDAY_VAL = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sec_tick,
  input  logic [SEC_W-1:0]   sec_cnt,
  input  logic [MIN_W-1:0]   min_cnt,
  input  logic [HOUR_W-1:0]  hour_cnt,
  input  logic [WDAY_W-1:0]  wday_cnt,
  input  logic [DATE_W-1:0]  date_cnt,
  input  logic [MONTH_W-1:0] month_cnt,
  input  logic [1:0]         time_sel,
  input  logic [1:0]         cal_sel,
  input  logic               utc_mode,
  input  logic               time_clr,
  input  logic               cal_clr,
  output logic               time_evt_flag,
  output logic               cal_evt_flag
);
  localparam int NFLAG = 2;

  logic [BND_COUNT-1:0] bnd_match, bnd_fire;
  logic [NFLAG-1:0]     flag_set, flag_clr, flag_q;
  time_sel_e            tsel;
  cal_sel_e             csel;

  rtc_evt_match #(
    .SEC_W(SEC_W), .MIN_W(MIN_W), .HOUR_W(HOUR_W), .WDAY_W(WDAY_W),
    .DATE_W(DATE_W), .MONTH_W(MONTH_W), .NOON_HOUR(NOON_HOUR),
    .MONDAY_VAL(MONDAY_VAL), .FIRST_DATE(1), .JAN_VAL(1)
  ) u_match (
    .sec_cnt(sec_cnt), .min_cnt(min_cnt), .hour_cnt(hour_cnt),
    .wday_cnt(wday_cnt), .date_cnt(date_cnt), .month_cnt(month_cnt),
    .match(bnd_match)
  );

  rtc_evt_edge #(.N(BND_COUNT)) u_edge (
    .clk(clk), .rst(rst), .tick(sec_tick), .match(bnd_match), .fire(bnd_fire)
  );

  always_comb begin
    tsel = time_sel_e'(time_sel);
    csel = cal_sel_e'(cal_sel);
    flag_set[0] = !utc_mode && bnd_fire[TIME_BASE + int'(tsel)];
    flag_set[1] = !utc_mode && (csel != CSEL_NONE) &&
                  bnd_fire[CAL_BASE + int'(csel[1:0] == 2'd3 ? 2'd0 : csel[1:0])];
    flag_clr    = {cal_clr, time_clr};
  end

  for (genvar f = 0; f < NFLAG; f++) begin : g_flag
    rtc_evt_flag u_flag (
      .clk(clk), .rst(rst), .set(flag_set[f]), .clr(flag_clr[f]), .flag(flag_q[f])
    );
  end

  assign time_evt_flag = flag_q[0];
  assign cal_evt_flag  = flag_q[1];

  AST_UTC_NO_TIME: assert property (@(posedge clk) disable iff (rst)
    $rose(time_evt_flag) |-> !$past(utc_mode));                 // R8
  AST_UTC_NO_CAL: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_evt_flag) |-> !$past(utc_mode));                  // R8
  AST_RESERVED_CAL: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_evt_flag) |-> ($past(cal_sel) != 2'd3));          // R7
  AST_TIME_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(time_evt_flag) |-> $past(sec_tick));                  // R9
endmodule

// File: tb/rtc_evt_detect_bench.sv
module rtc_evt_detect_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sec_tick = 1'b0;
  logic [5:0] sec_cnt = '0, min_cnt = '0;
  logic [4:0] hour_cnt = '0, date_cnt = 5'd1;
  logic [2:0] wday_cnt = 3'd1;
  logic [3:0] month_cnt = 4'd1;
  logic [1:0] time_sel = '0, cal_sel = '0;
  logic       utc_mode = 1'b0, time_clr = 1'b0, cal_clr = 1'b0;
  logic       time_evt_flag, cal_evt_flag;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  rtc_evt_detect u_rtc_evt_detect (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .sec_cnt(sec_cnt), .min_cnt(min_cnt),
    .hour_cnt(hour_cnt), .wday_cnt(wday_cnt), .date_cnt(date_cnt), .month_cnt(month_cnt),
    .time_sel(time_sel), .cal_sel(cal_sel), .utc_mode(utc_mode),
    .time_clr(time_clr), .cal_clr(cal_clr),
    .time_evt_flag(time_evt_flag), .cal_evt_flag(cal_evt_flag)
  );

  typedef struct packed {
    logic [1:0] ts; logic [1:0] cs; logic utc;
    logic [5:0] s; logic [5:0] m; logic [4:0] h;
    logic [2:0] w; logic [4:0] d; logic [3:0] mo;
    logic et; logic ec;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 1'b0, 6'd0,  6'd5,  5'd9,  3'd3, 5'd9,  4'd5, 1'b1, 1'b0}, // R2 minute
    '{2'd0, 2'd0, 1'b0, 6'd1,  6'd5,  5'd9,  3'd3, 5'd9,  4'd5, 1'b0, 1'b0}, // R2 miss
    '{2'd1, 2'd0, 1'b0, 6'd0,  6'd0,  5'd7,  3'd3, 5'd9,  4'd5, 1'b1, 1'b0}, // R3 hour
    '{2'd1, 2'd0, 1'b0, 6'd0,  6'd1,  5'd7,  3'd3, 5'd9,  4'd5, 1'b0, 1'b0}, // R3 miss
    '{2'd2, 2'd1, 1'b0, 6'd0,  6'd0,  5'd0,  3'd3, 5'd5,  4'd5, 1'b1, 1'b0}, // R4 midnight
    '{2'd2, 2'd0, 1'b0, 6'd0,  6'd0,  5'd12, 3'd3, 5'd9,  4'd5, 1'b0, 1'b0}, // R4 noon not midnight
    '{2'd3, 2'd0, 1'b0, 6'd0,  6'd0,  5'd12, 3'd3, 5'd9,  4'd5, 1'b1, 1'b0}, // R4 noon
    '{2'd0, 2'd0, 1'b0, 6'd0,  6'd0,  5'd0,  3'd1, 5'd9,  4'd5, 1'b1, 1'b1}, // R5 Monday
    '{2'd0, 2'd0, 1'b0, 6'd0,  6'd0,  5'd1,  3'd1, 5'd9,  4'd5, 1'b1, 1'b0}, // R5 Monday 01:00
    '{2'd1, 2'd1, 1'b0, 6'd0,  6'd0,  5'd0,  3'd4, 5'd1,  4'd5, 1'b1, 1'b1}, // R6 month
    '{2'd2, 2'd2, 1'b0, 6'd0,  6'd0,  5'd0,  3'd4, 5'd1,  4'd1, 1'b1, 1'b1}, // R6 year
    '{2'd3, 2'd2, 1'b0, 6'd0,  6'd0,  5'd0,  3'd4, 5'd1,  4'd2, 1'b0, 1'b0}, // R6 Feb 1
    '{2'd2, 2'd3, 1'b0, 6'd0,  6'd0,  5'd0,  3'd1, 5'd1,  4'd1, 1'b1, 1'b0}, // R7 reserved
    '{2'd0, 2'd2, 1'b1, 6'd0,  6'd0,  5'd0,  3'd1, 5'd1,  4'd1, 1'b0, 1'b0}  // R8 UTC
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic set_vals(input vec_t v);
    time_sel = v.ts; cal_sel = v.cs; utc_mode = v.utc;
    sec_cnt = v.s; min_cnt = v.m; hour_cnt = v.h;
    wday_cnt = v.w; date_cnt = v.d; month_cnt = v.mo;
  endtask

  // Drive at negedge, capture at posedge, sample at the following negedge
  task automatic step(input logic tk, input logic tc, input logic cc);
    sec_tick = tk; time_clr = tc; cal_clr = cc;
    @(posedge clk);
    @(negedge clk);
    sec_tick = 1'b0; time_clr = 1'b0; cal_clr = 1'b0;
  endtask

  // Clear both flags and present a non-boundary tick to clear edge history
  task automatic neutral();
    utc_mode = 1'b0;
    sec_cnt = 6'd30; min_cnt = 6'd30; hour_cnt = 5'd5;
    wday_cnt = 3'd3; date_cnt = 5'd15; month_cnt = 4'd6;
    step(1'b1, 1'b1, 1'b1);
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    step(1'b1, 1'b0, 1'b0);   // tick at 00:00:00 Monday Jan 1 during reset
    step(1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    check("R1 time flag after reset", time_evt_flag, 1'b0);
    check("R1 cal flag after reset",  cal_evt_flag,  1'b0);

    for (int i = 0; i < NV; i++) begin
      neutral();
      set_vals(VECS[i]);
      step(1'b1, 1'b0, 1'b0);
      check($sformatf("vector %0d time", i), time_evt_flag, VECS[i].et);
      check($sformatf("vector %0d cal", i),  cal_evt_flag,  VECS[i].ec);
    end

    // R9: repeat tick with same matching values does not refire
    neutral();
    set_vals(VECS[10]);
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    check("R10 clear alone drops time", time_evt_flag, 1'b0);
    check("R10 clear alone drops cal",  cal_evt_flag,  1'b0);
    step(1'b1, 1'b0, 1'b0);
    check("R9 no refire time", time_evt_flag, 1'b0);
    check("R9 no refire cal",  cal_evt_flag,  1'b0);

    // R9: boundary values without a tick do not fire
    neutral();
    set_vals(VECS[10]);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    check("R9 no tick no time event", time_evt_flag, 1'b0);
    check("R9 no tick no cal event",  cal_evt_flag,  1'b0);

    // R10: sticky across non-boundary ticks
    step(1'b1, 1'b0, 1'b0);
    sec_cnt = 6'd7;
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    check("R10 time flag sticky", time_evt_flag, 1'b1);
    check("R10 cal flag sticky",  cal_evt_flag,  1'b1);

    // R10: event and clear in same cycle keep flag set
    neutral();
    set_vals(VECS[10]);
    step(1'b1, 1'b1, 1'b1);
    check("R10 set beats clear time", time_evt_flag, 1'b1);
    check("R10 set beats clear cal",  cal_evt_flag,  1'b1);

    // R8: leaving UTC mode on a held boundary value does not fire
    neutral();
    set_vals(VECS[13]);
    step(1'b1, 1'b0, 1'b0);
    utc_mode = 1'b0;
    step(1'b1, 1'b0, 1'b0);
    check("R8 held value after UTC time", time_evt_flag, 1'b0);
    check("R8 held value after UTC cal",  cal_evt_flag,  1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule